// File: doc/BRIEF.md
# 16-bit ModR/M Effective Address Unit

This block decodes the addressing byte that follows an opcode in 16-bit addressing mode. It receives the addressing byte, a direction bit taken from the opcode, the two bytes that follow the addressing byte (the possible displacement), and the current contents of the four registers that can form an address: BX, BP, SI and DI. It works out whether the r/m operand is a register or a memory location, and how many displacement bytes the instruction consumes. For a memory operand it also works out the 16-bit effective address and the default segment.

The block also resolves the direction of the transfer. It reports the 3-bit register index of the source operand and of the destination operand, and flags which side is memory. This lets a decoder steer the register file and the memory port without decoding the addressing byte again. Register-file reads, segment translation and the transfer itself belong to the surrounding pipeline.

All results are registered. They appear one clock after a request is presented with `req_valid` high, and they hold until the next request.

Top module: `ea16_unit`

## Requirements
- R1: The addressing byte is split into mode (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). Mode 11 marks a register operand. In that case `rm_is_mem`=0 and `disp_bytes`=0, and both operand indices come straight from the reg and r/m fields.
- R2: With `reg_is_dst`=1 (the opcode loads the reg operand from r/m), `dst_idx` is the reg field and `src_idx` is the r/m field, and `src_is_mem` carries the memory flag. With `reg_is_dst`=0 the roles swap and `dst_is_mem` carries the flag. At most one of the two memory flags is ever set.
- R3: In mode 00 with r/m other than 110, `disp_bytes`=0 and the address is the plain register combination from R7.
- R4: In mode 00 with r/m=110, the address is the direct value {`disp_hi`,`disp_lo`}, `disp_bytes`=2 and the segment is DS.
- R5: In mode 01, `disp_bytes`=1 and `disp_lo` is sign-extended to 16 bits and added to the combination from R7.
- R6: In mode 10, `disp_bytes`=2 and {`disp_hi`,`disp_lo`} (little-endian) is added to the combination from R7.
- R7: The r/m codes select these combinations: 000=BX+SI, 001=BX+DI, 010=BP+SI, 011=BP+DI, 100=SI, 101=DI, 110=BP (only in modes 01 and 10), 111=BX. A bare BP address is therefore mode 01, r/m 110 with a displacement of 0x00.
- R8: The effective address is the sum modulo 2^16.
- R9: `seg_ss`=1 (stack segment) exactly when a memory mode uses BP as a term. Otherwise `seg_ss`=0 (data segment). For a register operand, `seg_ss`=0 and `ea`=0.
- R10: Results appear on the clock edge that samples `req_valid`=1. `rsp_valid` equals `req_valid` delayed by one cycle. The result fields hold while `req_valid` is low. Reset clears `rsp_valid` and all result fields to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; fields are captured when high |
| modrm | input | 8 | Addressing byte |
| reg_is_dst | input | 1 | Direction bit from the opcode: 1 means the reg operand is the destination |
| disp_lo | input | 8 | First byte after the addressing byte |
| disp_hi | input | 8 | Second byte after the addressing byte |
| bx_val | input | 16 | Current BX |
| bp_val | input | 16 | Current BP |
| si_val | input | 16 | Current SI |
| di_val | input | 16 | Current DI |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rm_is_mem | output | 1 | r/m operand is a memory location |
| disp_bytes | output | 2 | Displacement bytes consumed (0, 1 or 2) |
| ea | output | 16 | Effective address (0 for a register operand) |
| seg_ss | output | 1 | Default segment: 1 = SS, 0 = DS |
| src_idx | output | 3 | Register index of the source operand |
| src_is_mem | output | 1 | Source operand is the memory location |
| dst_idx | output | 3 | Register index of the destination operand |
| dst_is_mem | output | 1 | Destination operand is the memory location |

## Verification
Every result field is due exactly one rising edge after the request that `req_valid` qualifies. The bench therefore drives each request on a falling edge, lets one rising edge pass, and samples all outputs on the following falling edge, before any new request can reach the registers. The sweep covers all 256 addressing bytes in both directions over several register and displacement patterns, including patterns that wrap past 0xFFFF and negative 8-bit displacements. For the hold check the bench drops `req_valid`, changes every input, and after the next edge confirms that `rsp_valid` is low and that the previous fields are unchanged.

// File: rtl/ea16_pkg.sv
package ea16_pkg;

    localparam int EA_W    = 16;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = 3;
    localparam int DLEN_W  = 2;
    localparam int EXT_W   = EA_W - BYTE_W;

    localparam logic [IDX_W-1:0] RM_DIRECT = 3'b110;

    typedef enum logic [1:0] {
        MODE_NODISP = 2'b00,
        MODE_DISP8  = 2'b01,
        MODE_DISP16 = 2'b10,
        MODE_REGOP  = 2'b11
    } mode_e;

    typedef enum logic {
        SEG_DATA  = 1'b0,
        SEG_STACK = 1'b1
    } seg_e;

    typedef struct packed {
        mode_e            mode;
        logic [IDX_W-1:0] reg_f;
        logic [IDX_W-1:0] rm_f;
    } addr_byte_t;

    typedef struct packed {
        logic take_bx;
        logic take_bp;
        logic take_si;
        logic take_di;
    } term_sel_t;

    typedef struct packed {
        logic              is_mem;
        logic [DLEN_W-1:0] dlen;
        logic [EA_W-1:0]   addr;
        seg_e              seg;
        logic [IDX_W-1:0]  src;
        logic              src_mem;
        logic [IDX_W-1:0]  dst;
        logic              dst_mem;
    } ea_result_t;

    // r/m bit 2 chooses between a two-term and a one-term form;
    // bit 1 picks the base (or index-vs-base) and bit 0 refines it.
    function automatic term_sel_t pick_terms(input logic [IDX_W-1:0] rm);
        term_sel_t s;
        s = '0;
        if (!rm[2]) begin
            s.take_bp = rm[1];
            s.take_bx = !rm[1];
            s.take_di = rm[0];
            s.take_si = !rm[0];
        end else if (!rm[1]) begin
            s.take_di = rm[0];
            s.take_si = !rm[0];
        end else begin
            s.take_bx = rm[0];
            s.take_bp = !rm[0];
        end
        return s;
    endfunction

    function automatic logic [DLEN_W-1:0] disp_len_of(input mode_e m, input logic direct);
        logic [DLEN_W-1:0] n;
        case (m)
            MODE_DISP8:  n = 2'd1;
            MODE_DISP16: n = 2'd2;
            MODE_NODISP: n = direct ? 2'd2 : 2'd0;
            default:     n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ea16_field_dec.sv
module ea16_field_dec
    import ea16_pkg::*;
(
    input  logic [BYTE_W-1:0] modrm_byte,
    output addr_byte_t        fields,
    output logic              mem_op,
    output logic              direct,
    output logic [DLEN_W-1:0] n_disp
);

    always_comb begin
        fields = addr_byte_t'(modrm_byte);
        mem_op = (fields.mode != MODE_REGOP);
        direct = (fields.mode == MODE_NODISP) && (fields.rm_f == RM_DIRECT);
        n_disp = disp_len_of(fields.mode, direct);
    end

endmodule

// File: rtl/ea16_term_sel.sv
module ea16_term_sel
    import ea16_pkg::*;
(
    input  logic [IDX_W-1:0] rm_f,
    input  logic             mem_op,
    input  logic             direct,
    input  logic [EA_W-1:0]  bx_v,
    input  logic [EA_W-1:0]  bp_v,
    input  logic [EA_W-1:0]  si_v,
    input  logic [EA_W-1:0]  di_v,
    output logic [EA_W-1:0]  base_term,
    output logic [EA_W-1:0]  index_term,
    output seg_e             seg
);

    term_sel_t sel;

    always_comb begin
        sel = pick_terms(rm_f);
        if (!mem_op || direct) begin
            sel = '0;
        end
        base_term  = ({EA_W{sel.take_bx}} & bx_v) | ({EA_W{sel.take_bp}} & bp_v);
        index_term = ({EA_W{sel.take_si}} & si_v) | ({EA_W{sel.take_di}} & di_v);
        seg        = sel.take_bp ? SEG_STACK : SEG_DATA;
    end

endmodule

// File: rtl/ea16_disp_ext.sv
module ea16_disp_ext
    import ea16_pkg::*;
(
    input  mode_e             mode,
    input  logic              direct,
    input  logic [BYTE_W-1:0] lo_b,
    input  logic [BYTE_W-1:0] hi_b,
    output logic [EA_W-1:0]   disp_val
);

    logic [EA_W-1:0] wide_v;
    logic [EA_W-1:0] short_v;

    always_comb begin
        wide_v  = {{(EA_W - 2*BYTE_W){1'b0}}, hi_b, lo_b};
        short_v = {{EXT_W{lo_b[BYTE_W-1]}}, lo_b};
        case (mode)
            MODE_DISP8:  disp_val = short_v;
            MODE_DISP16: disp_val = wide_v;
            MODE_NODISP: disp_val = direct ? wide_v : '0;
            default:     disp_val = '0;
        endcase
    end

endmodule

// File: rtl/ea16_route.sv
module ea16_route
    import ea16_pkg::*;
(
    input  logic [IDX_W-1:0] reg_f,
    input  logic [IDX_W-1:0] rm_f,
    input  logic             reg_is_dst,
    input  logic             mem_op,
    output logic [IDX_W-1:0] src,
    output logic             src_mem,
    output logic [IDX_W-1:0] dst,
    output logic             dst_mem
);

    always_comb begin
        if (reg_is_dst) begin
            dst     = reg_f;
            src     = rm_f;
            src_mem = mem_op;
            dst_mem = 1'b0;
        end else begin
            src     = reg_f;
            dst     = rm_f;
            dst_mem = mem_op;
            src_mem = 1'b0;
        end
    end

endmodule

// File: rtl/ea16_unit.sv
module ea16_unit
    import ea16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BYTE_W-1:0] modrm,
    input  logic              reg_is_dst,
    input  logic [BYTE_W-1:0] disp_lo,
    input  logic [BYTE_W-1:0] disp_hi,
    input  logic [EA_W-1:0]   bx_val,
    input  logic [EA_W-1:0]   bp_val,
    input  logic [EA_W-1:0]   si_val,
    input  logic [EA_W-1:0]   di_val,
    output logic              rsp_valid,
    output logic              rm_is_mem,
    output logic [DLEN_W-1:0] disp_bytes,
    output logic [EA_W-1:0]   ea,
    output logic              seg_ss,
    output logic [IDX_W-1:0]  src_idx,
    output logic              src_is_mem,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              dst_is_mem
);

    addr_byte_t        f;
    logic              mem_op;
    logic              direct;
    logic [DLEN_W-1:0] n_disp;
    logic [EA_W-1:0]   base_term;
    logic [EA_W-1:0]   index_term;
    logic [EA_W-1:0]   disp_val;
    seg_e              seg;
    logic [IDX_W-1:0]  src_c;
    logic [IDX_W-1:0]  dst_c;
    logic              src_mem_c;
    logic              dst_mem_c;
    ea_result_t        nxt;
    ea_result_t        cur;
    logic              vld_q;

    ea16_field_dec u_dec (
        .modrm_byte (modrm),
        .fields     (f),
        .mem_op     (mem_op),
        .direct     (direct),
        .n_disp     (n_disp)
    );

    ea16_term_sel u_terms (
        .rm_f       (f.rm_f),
        .mem_op     (mem_op),
        .direct     (direct),
        .bx_v       (bx_val),
        .bp_v       (bp_val),
        .si_v       (si_val),
        .di_v       (di_val),
        .base_term  (base_term),
        .index_term (index_term),
        .seg        (seg)
    );

    ea16_disp_ext u_disp (
        .mode     (f.mode),
        .direct   (direct),
        .lo_b     (disp_lo),
        .hi_b     (disp_hi),
        .disp_val (disp_val)
    );

    ea16_route u_route (
        .reg_f      (f.reg_f),
        .rm_f       (f.rm_f),
        .reg_is_dst (reg_is_dst),
        .mem_op     (mem_op),
        .src        (src_c),
        .src_mem    (src_mem_c),
        .dst        (dst_c),
        .dst_mem    (dst_mem_c)
    );

    always_comb begin
        nxt.is_mem  = mem_op;
        nxt.dlen    = n_disp;
        nxt.addr    = base_term + index_term + disp_val;
        nxt.seg     = seg;
        nxt.src     = src_c;
        nxt.src_mem = src_mem_c;
        nxt.dst     = dst_c;
        nxt.dst_mem = dst_mem_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                cur <= nxt;
            end
        end
    end

    assign rsp_valid  = vld_q;
    assign rm_is_mem  = cur.is_mem;
    assign disp_bytes = cur.dlen;
    assign ea         = cur.addr;
    assign seg_ss     = (cur.seg == SEG_STACK);
    assign src_idx    = cur.src;
    assign src_is_mem = cur.src_mem;
    assign dst_idx    = cur.dst;
    assign dst_is_mem = cur.dst_mem;

    // R10: one-cycle latency, fields hold while idle
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && $stable(ea) && $stable(disp_bytes)));

    // R1 / R9: register operand carries no displacement, no address, DS
    p_regop_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rm_is_mem) |-> (disp_bytes == 2'd0 && ea == '0 && !seg_ss));

    // R2: never both sides memory; loads never write memory
    p_one_mem_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0({src_is_mem, dst_is_mem}));
    p_load_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(reg_is_dst)) |-> (!dst_is_mem && dst_idx == $past(modrm[5:3])));

    // R5: short displacement mode consumes exactly one byte
    p_d8_len_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(modrm[7:6]) == 2'b01) |-> (disp_bytes == 2'd1 && rm_is_mem));

    // R4: direct form is DS-relative with two bytes
    p_direct_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(modrm[7:6]) == 2'b00 && $past(modrm[2:0]) == 3'b110)
            |-> (disp_bytes == 2'd2 && !seg_ss && ea == {$past(disp_hi), $past(disp_lo)}));

    // R9: stack segment only for memory operands
    p_seg_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && seg_ss) |-> rm_is_mem);

endmodule

// File: tb/ea16_unit_tb.sv
`timescale 1ns/1ps
module ea16_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  modrm = '0;
    logic        reg_is_dst = 1'b0;
    logic [7:0]  disp_lo = '0;
    logic [7:0]  disp_hi = '0;
    logic [15:0] bx_val = '0, bp_val = '0, si_val = '0, di_val = '0;
    logic        rsp_valid, rm_is_mem, seg_ss, src_is_mem, dst_is_mem;
    logic [1:0]  disp_bytes;
    logic [15:0] ea;
    logic [2:0]  src_idx, dst_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ea16_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .modrm(modrm),
        .reg_is_dst(reg_is_dst), .disp_lo(disp_lo), .disp_hi(disp_hi),
        .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
        .rsp_valid(rsp_valid), .rm_is_mem(rm_is_mem), .disp_bytes(disp_bytes),
        .ea(ea), .seg_ss(seg_ss), .src_idx(src_idx), .src_is_mem(src_is_mem),
        .dst_idx(dst_idx), .dst_is_mem(dst_is_mem)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h (modrm=0x%02h dir=%0b)",
                     tag, what, act, exp, modrm, reg_is_dst);
        end
    endtask

    // Expected values built from the requirement tables.
    logic        e_mem, e_ss, e_smem, e_dmem;
    logic [1:0]  e_len;
    logic [15:0] e_ea;
    logic [2:0]  e_src, e_dst;

    task automatic model();
        logic [1:0]  md;
        logic [2:0]  rg, rm;
        logic [15:0] sum, d;
        md = modrm[7:6]; rg = modrm[5:3]; rm = modrm[2:0];
        e_mem = (md != 2'd3);
        // R7 combinations
        case (rm)
            3'd0: begin sum = bx_val + si_val; e_ss = 0; end
            3'd1: begin sum = bx_val + di_val; e_ss = 0; end
            3'd2: begin sum = bp_val + si_val; e_ss = 1; end
            3'd3: begin sum = bp_val + di_val; e_ss = 1; end
            3'd4: begin sum = si_val;          e_ss = 0; end
            3'd5: begin sum = di_val;          e_ss = 0; end
            3'd6: begin sum = bp_val;          e_ss = 1; end
            default: begin sum = bx_val;       e_ss = 0; end
        endcase
        if (md == 2'd0 && rm == 3'd6) begin          // R4
            e_len = 2; e_ea = {disp_hi, disp_lo}; e_ss = 0;
        end else if (md == 2'd0) begin               // R3
            e_len = 0; e_ea = sum;
        end else if (md == 2'd1) begin               // R5
            d = disp_lo[7] ? (16'hFF00 | disp_lo) : {8'h00, disp_lo};
            e_len = 1; e_ea = sum + d;
        end else if (md == 2'd2) begin               // R6
            e_len = 2; e_ea = sum + (disp_hi * 16'd256 + disp_lo);
        end else begin                               // R1
            e_len = 0; e_ea = 0; e_ss = 0;
        end
        if (reg_is_dst) begin e_dst = rg; e_src = rm; e_smem = e_mem; e_dmem = 0; end
        else            begin e_src = rg; e_dst = rm; e_dmem = e_mem; e_smem = 0; end
    endtask

    task automatic apply_and_check();
        string t;
        req_valid = 1'b1;
        model();
        @(posedge clk);
        @(negedge clk);
        case (modrm[7:6])
            2'd0: t = (modrm[2:0] == 3'd6) ? "R4" : "R3";
            2'd1: t = "R5";
            2'd2: t = "R6";
            default: t = "R1";
        endcase
        chk("R10", "rsp_valid", rsp_valid, 1);
        chk("R1", "rm_is_mem", rm_is_mem, e_mem);
        chk(t, "disp_bytes", disp_bytes, e_len);
        chk((modrm[7:6] == 2'd3) ? "R9" : "R8", "ea", ea, e_ea);
        chk("R9", "seg_ss", seg_ss, e_ss);
        chk("R2", "src_idx", src_idx, e_src);
        chk("R2", "dst_idx", dst_idx, e_dst);
        chk("R2", "src_is_mem", src_is_mem, e_smem);
        chk("R2", "dst_is_mem", dst_is_mem, e_dmem);
    endtask

    task automatic set_pattern(input int p);
        case (p)
            0: begin bx_val = 16'h1234; bp_val = 16'hFF00; si_val = 16'h0101; di_val = 16'h8000; disp_lo = 8'h7F; disp_hi = 8'h12; end
            1: begin bx_val = 16'hFFFF; bp_val = 16'h0001; si_val = 16'hFFFF; di_val = 16'h0002; disp_lo = 8'h80; disp_hi = 8'hFE; end
            default: begin bx_val = 16'h0F0F; bp_val = 16'h7FFE; si_val = 16'hF00D; di_val = 16'hABCD; disp_lo = 8'hFF; disp_hi = 8'hFF; end
        endcase
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog: actual=timeout expected=completion");
                    $display("Result: errors=%0d of %0d checks", errors, checks);
                    $finish;
                end
            end
        join_none

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset rsp_valid", rsp_valid, 0);
        chk("R10", "reset ea", ea, 0);
        chk("R10", "reset disp_bytes", disp_bytes, 0);
        chk("R10", "reset rm_is_mem", rm_is_mem, 0);
        rst = 1'b0;

        // R7: bare BP needs mode 01, r/m 110, displacement 0x00
        set_pattern(0);
        bp_val = 16'h4000; disp_lo = 8'h00; modrm = 8'h76; reg_is_dst = 1'b1;
        apply_and_check();
        chk("R7", "bare BP ea", ea, 16'h4000);
        chk("R7", "bare BP seg", seg_ss, 1);

        // R1: 0xD0 register pair, reg=2, r/m=0
        modrm = 8'hD0; reg_is_dst = 1'b0;
        apply_and_check();
        chk("R1", "0xD0 src", src_idx, 2);
        chk("R1", "0xD0 dst", dst_idx, 0);

        // Full sweep
        for (int p = 0; p < 3; p++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int m = 0; m < 256; m++) begin
                    set_pattern(p);
                    modrm = m[7:0];
                    reg_is_dst = dir[0];
                    apply_and_check();
                end
            end
        end

        // R10: idle cycle holds fields while inputs change
        set_pattern(1);
        modrm = 8'h42; reg_is_dst = 1'b0;
        apply_and_check();
        req_valid = 1'b0;
        modrm = 8'h87; disp_lo = 8'h11; bx_val = 16'h0000; si_val = 16'h0000;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "idle rsp_valid", rsp_valid, 0);
        chk("R10", "idle ea hold", ea, e_ea);
        chk("R10", "idle disp hold", disp_bytes, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule